// File: doc/BRIEF.md
# Phase-Staggered Switching Timing Generator

This block turns one fast system clock into the period-start strobes of a four-output switching power controller. A divisor input gives the length of the base switching period in system clocks. With a nominal 103 MHz system clock, a base rate between 105 kHz and 306 kHz needs a divisor between 336 and 981. A single shared period counter runs across that period. Each channel selects its own rate: one, two or four strobes per base period. Each channel is also shifted in phase by a fixed fraction of the period, so the four outputs never all switch on the same edge.

All pins are plain control and status lines. There is no data stream and no handshake. The divisor and the rate selects are level inputs and are sampled only at a period boundary. Every output is a registered strobe that lasts one system clock. A downstream duty generator would start a new switching cycle on each channel strobe and use the base strobe as a common time reference.

Top module: `swt_timing_top`

## Requirements
- R1: With an effective divisor N, `base_pulse` is high for one cycle in every N system clocks, and the spacing between consecutive base pulses is exactly N cycles.
- R2: A requested divisor below 336 is used as 336, and a requested divisor above 981 is used as 981. Values from 336 to 981 inclusive are used as given.
- R3: A channel whose 2-bit rate select is 01 pulses twice per base period, at relative positions 0 and floor(N/2).
- R4: A channel whose rate select is 10 pulses four times per base period, at relative positions 0, floor(N/4), floor(N/2) and floor(3N/4).
- R5: A channel whose rate select is 00 pulses once per base period, at relative position 0. The reserved code 11 behaves exactly like 00.
- R6: Relative positions of channel k (k = 0..3) are measured from k*floor(N/4) system clocks after the base pulse, taken modulo N. Channel 0 therefore always pulses together with `base_pulse`.
- R7: A change of the divisor or of any rate select that arrives in the middle of a period does not alter that period. It takes effect from the next base pulse on.
- R8: While `rst_n` is low, all outputs are 0. After release, all outputs stay 0 on the first rising edge. The first `base_pulse`, together with channel 0, appears after the second rising edge.
- R9: Every output pulse lasts exactly one system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_cfg | input | 10 | Requested base period in system clocks, clamped to 336..981 |
| ch_mult | input | 8 | Rate selects, 2 bits per channel, channel k in bits [2k+1:2k]: 00 and 11 give 1x, 01 gives 2x, 10 gives 4x |
| base_pulse | output | 1 | One-cycle strobe at the start of each base period |
| ch_pulse | output | 4 | One-cycle period-start strobe per channel, bit k for channel k |

## Verification
The in-line properties watch the following on every cycle:
- the period counter never reaching the latched period;
- the latched period staying inside the clamp window;
- the configuration holding steady between boundaries;
- channel 0 coinciding with the base strobe;
- the base strobe lasting one cycle;
- silence before the first period.

The exact phase placement of each channel under each rate code can only be shown by the bench's scenarios, which compare cycle by cycle against a model of the requirements. The same holds for the clamped period lengths, for a mid-period reprogramming taking effect only at the next boundary, and for the exact cycle of the first pulse after reset.

// File: rtl/swt_timing_pkg.sv
package swt_timing_pkg;

  // Per-channel rate selection; the reserved code falls back to 1x.
  typedef enum logic [1:0] {
    RATE_X1  = 2'b00,
    RATE_X2  = 2'b01,
    RATE_X4  = 2'b10,
    RATE_RSV = 2'b11
  } rate_sel_e;

  localparam int RATE_W = 2;

endpackage

// File: rtl/swt_div_clamp.sv
module swt_div_clamp #(
  parameter int DIV_W   = 10,
  parameter int DIV_MIN = 336,
  parameter int DIV_MAX = 981
) (
  input  logic [DIV_W-1:0] raw_div,
  output logic [DIV_W-1:0] eff_div
);
  localparam logic [DIV_W-1:0] LO = DIV_W'(DIV_MIN);
  localparam logic [DIV_W-1:0] HI = DIV_W'(DIV_MAX);

  always_comb begin
    if (raw_div < LO)      eff_div = LO;
    else if (raw_div > HI) eff_div = HI;
    else                   eff_div = raw_div;
  end
endmodule

// File: rtl/swt_period_engine.sv
module swt_period_engine
  import swt_timing_pkg::*;
#(
  parameter int DIV_W   = 10,
  parameter int DIV_MIN = 336,
  parameter int DIV_MAX = 981,
  parameter int NUM_CH  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [DIV_W-1:0]           eff_div,
  input  logic [RATE_W*NUM_CH-1:0]   rate_in,
  output logic                       active,
  output logic                       period_start,
  output logic [DIV_W-1:0]           cnt,
  output logic [DIV_W-1:0]           per_len,
  output logic [DIV_W-1:0]           per_q1,
  output logic [DIV_W-1:0]           per_q2,
  output logic [DIV_W-1:0]           per_q3,
  output logic [RATE_W*NUM_CH-1:0]   rate_q
);
  localparam int WW = DIV_W + 2;

  logic          boundary;
  logic [WW-1:0] triple;

  assign triple       = WW'(eff_div) * WW'(3);
  assign boundary     = !active || (cnt == per_len - DIV_W'(1));
  assign period_start = active && (cnt == '0);

  // Geometry and rate selects are captured only at a boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cnt     <= '0;
      per_len <= DIV_W'(DIV_MIN);
      per_q1  <= '0;
      per_q2  <= '0;
      per_q3  <= '0;
      rate_q  <= '0;
    end else if (boundary) begin
      active  <= 1'b1;
      cnt     <= '0;
      per_len <= eff_div;
      per_q1  <= eff_div >> 2;
      per_q2  <= eff_div >> 1;
      per_q3  <= DIV_W'(triple >> 2);
      rate_q  <= rate_in;
    end else begin
      cnt     <= cnt + DIV_W'(1);
    end
  end

  // R1: the counter always stays inside the current period
  a_r1_count_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt < per_len));

  // R2: the latched period never leaves the clamp window
  a_r2_period_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    (per_len >= DIV_W'(DIV_MIN)) && (per_len <= DIV_W'(DIV_MAX)));

  // R7: no reconfiguration away from a boundary
  a_r7_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (cnt != per_len - DIV_W'(1))) |=>
      ($stable(per_len) && $stable(rate_q) && $stable(per_q1)));
endmodule

// File: rtl/swt_phase_slot.sv
module swt_phase_slot
  import swt_timing_pkg::*;
#(
  parameter int DIV_W  = 10,
  parameter int CH_IDX = 0
) (
  input  logic             active,
  input  logic [DIV_W-1:0] cnt,
  input  logic [DIV_W-1:0] per_len,
  input  logic [DIV_W-1:0] per_q1,
  input  logic [DIV_W-1:0] per_q2,
  input  logic [DIV_W-1:0] per_q3,
  input  rate_sel_e        rate,
  output logic             hit
);
  localparam int OW = DIV_W + 2;

  logic [OW-1:0]    off_raw;
  logic [DIV_W-1:0] off;
  logic [DIV_W:0]   rel_w;
  logic [DIV_W-1:0] rel;

  assign off_raw = OW'(CH_IDX) * OW'(per_q1);

  always_comb begin
    if (off_raw >= OW'(per_len)) off = DIV_W'(off_raw - OW'(per_len));
    else                         off = DIV_W'(off_raw);
  end

  // Position within this channel's shifted period, modulo the period.
  always_comb begin
    if (cnt >= off) rel_w = (DIV_W+1)'(cnt) - (DIV_W+1)'(off);
    else            rel_w = (DIV_W+1)'(cnt) + (DIV_W+1)'(per_len) - (DIV_W+1)'(off);
    rel = rel_w[DIV_W-1:0];
  end

  always_comb begin
    unique case (rate)
      RATE_X2: hit = (rel == '0) || (rel == per_q2);
      RATE_X4: hit = (rel == '0) || (rel == per_q1) ||
                     (rel == per_q2) || (rel == per_q3);
      default: hit = (rel == '0);
    endcase
    hit = hit && active;
  end
endmodule

// File: rtl/swt_timing_top.sv
module swt_timing_top
  import swt_timing_pkg::*;
#(
  parameter int DIV_W   = 10,
  parameter int DIV_MIN = 336,
  parameter int DIV_MAX = 981,
  parameter int NUM_CH  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DIV_W-1:0]         div_cfg,
  input  logic [RATE_W*NUM_CH-1:0] ch_mult,
  output logic                     base_pulse,
  output logic [NUM_CH-1:0]        ch_pulse
);
  logic [DIV_W-1:0]         eff_div;
  logic                     eng_active;
  logic                     eng_start;
  logic [DIV_W-1:0]         cnt;
  logic [DIV_W-1:0]         per_len;
  logic [DIV_W-1:0]         per_q1;
  logic [DIV_W-1:0]         per_q2;
  logic [DIV_W-1:0]         per_q3;
  logic [RATE_W*NUM_CH-1:0] rate_q;
  logic [NUM_CH-1:0]        slot_hit;

  swt_div_clamp #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)) u_clamp (
    .raw_div (div_cfg),
    .eff_div (eff_div)
  );

  swt_period_engine #(
    .DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX), .NUM_CH(NUM_CH)
  ) u_engine (
    .clk          (clk),
    .rst_n        (rst_n),
    .eff_div      (eff_div),
    .rate_in      (ch_mult),
    .active       (eng_active),
    .period_start (eng_start),
    .cnt          (cnt),
    .per_len      (per_len),
    .per_q1       (per_q1),
    .per_q2       (per_q2),
    .per_q3       (per_q3),
    .rate_q       (rate_q)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_slot
    swt_phase_slot #(.DIV_W(DIV_W), .CH_IDX(k)) u_slot (
      .active  (eng_active),
      .cnt     (cnt),
      .per_len (per_len),
      .per_q1  (per_q1),
      .per_q2  (per_q2),
      .per_q3  (per_q3),
      .rate    (rate_sel_e'(rate_q[RATE_W*k +: RATE_W])),
      .hit     (slot_hit[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_pulse <= 1'b0;
      ch_pulse   <= '0;
    end else begin
      base_pulse <= eng_start;
      ch_pulse   <= slot_hit;
    end
  end

  // R6: channel 0 carries no phase shift
  a_r6_ch0_with_base: assert property (@(posedge clk) disable iff (!rst_n)
    base_pulse |-> ch_pulse[0]);

  // R9: the base strobe is a single cycle
  a_r9_base_single: assert property (@(posedge clk) disable iff (!rst_n)
    base_pulse |=> !base_pulse);

  // R8: nothing is emitted before the first period has begun
  a_r8_quiet_before_start: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_active |=> (!base_pulse && (ch_pulse == '0)));
endmodule

// File: tb/swt_timing_top_test.sv
module swt_timing_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] div_cfg = 10'd400;
  logic [7:0] ch_mult = 8'b11_10_01_00;
  logic       base_pulse;
  logic [3:0] ch_pulse;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  typedef struct packed {
    logic       b;
    logic [3:0] c;
    logic [7:0] m;
  } exp_t;
  exp_t sb_q[$];

  // Model state
  int         m_n = 336;
  int         m_cnt = 0;
  bit         m_on = 0;
  logic [7:0] m_mult = '0;

  always #2.5 clk = ~clk;

  swt_timing_top uut (
    .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .ch_mult(ch_mult),
    .base_pulse(base_pulse), .ch_pulse(ch_pulse)
  );

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int clampv(input int d);
    if (d < 336) return 336;
    if (d > 981) return 981;
    return d;
  endfunction

  function automatic bit model_tick(input int k, input int c, input int n, input logic [1:0] m);
    int off, rel;
    off = (k * (n / 4)) % n;
    rel = (c - off + n) % n;
    case (m)
      2'b01:   return (rel == 0) || (rel == n / 2);
      2'b10:   return (rel == 0) || (rel == n / 4) || (rel == n / 2) || (rel == (3 * n) / 4);
      default: return rel == 0;
    endcase
  endfunction

  function automatic string rate_tag(input logic [1:0] m);
    case (m)
      2'b01:   return "R3 R6 ch";
      2'b10:   return "R4 R6 ch";
      default: return "R5 R6 ch";
    endcase
  endfunction

  // Driver side: model advances on each edge and queues the outputs expected after it
  always @(posedge clk) begin
    exp_t e;
    e = '0;
    cyc++;
    if (!rst_n) begin
      m_on = 0;
      m_cnt = 0;
    end else begin
      e.b = m_on && (m_cnt == 0);
      e.m = m_mult;
      for (int k = 0; k < 4; k++)
        e.c[k] = m_on && model_tick(k, m_cnt, m_n, m_mult[2*k +: 2]);
      if (!m_on || m_cnt == m_n - 1) begin
        m_n = clampv(int'(div_cfg));
        m_mult = ch_mult;
        m_cnt = 0;
        m_on = 1;
      end else begin
        m_cnt++;
      end
    end
    sb_q.push_back(e);
  end

  // Monitor side: compare away from the active edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk("R1 base_pulse", int'(base_pulse), int'(e.b));
      for (int k = 0; k < 4; k++)
        chk($sformatf("%s%0d", rate_tag(e.m[2*k +: 2]), k), int'(ch_pulse[k]), int'(e.c[k]));
    end
  end

  task automatic wait_base();
    do @(negedge clk); while (base_pulse !== 1'b1);
  endtask

  task automatic measure(input string tag, input int exp);
    int t0;
    wait_base();
    t0 = cyc;
    wait_base();
    chk(tag, cyc - t0, exp);
  endtask

  task automatic count_pulses(input int n, input int e0, input int e1, input int e2, input int e3);
    int c[4];
    c = '{0, 0, 0, 0};
    wait_base();
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 4; k++) c[k] += int'(ch_pulse[k]);
      @(negedge clk);
    end
    chk(rate_tag(ch_mult[1:0]), c[0], e0);
    chk(rate_tag(ch_mult[3:2]), c[1], e1);
    chk(rate_tag(ch_mult[5:4]), c[2], e2);
    chk(rate_tag(ch_mult[7:6]), c[3], e3);
  endtask

  task automatic print_summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL R1 watchdog: actual %0d cycles expected fewer than 150000", cyc);
    print_summary();
    $finish;
  end

  initial begin : main
    int t0;
    // R8: held in reset
    repeat (5) @(negedge clk);
    chk("R8 reset base", int'(base_pulse), 0);
    chk("R8 reset ch", int'(ch_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 first edge base", int'(base_pulse), 0);
    chk("R8 first edge ch", int'(ch_pulse), 0);
    @(negedge clk);
    chk("R8 second edge base", int'(base_pulse), 1);
    chk("R8 second edge ch0", int'(ch_pulse[0]), 1);
    @(negedge clk);
    chk("R9 base one cycle", int'(base_pulse), 0);

    // Mixed rates: ch0 1x, ch1 2x, ch2 4x, ch3 reserved
    measure("R1 period 400", 400);
    count_pulses(400, 1, 2, 4, 1);

    // R7: reprogram in mid-period
    wait_base();
    t0 = cyc;
    repeat (60) @(negedge clk);
    div_cfg = 10'd500;
    ch_mult = 8'b10_10_10_10;
    wait_base();
    chk("R7 old period kept", cyc - t0, 400);
    measure("R1 period 500", 500);
    count_pulses(500, 4, 4, 4, 4);

    // R2: clamping at both ends
    div_cfg = 10'd100;
    ch_mult = 8'b01_01_01_01;
    measure("R2 low clamp", 336);
    count_pulses(336, 2, 2, 2, 2);
    div_cfg = 10'd1023;
    ch_mult = 8'b00_11_10_01;
    measure("R2 high clamp", 981);
    count_pulses(981, 2, 4, 1, 1);

    // Period not a multiple of four
    div_cfg = 10'd337;
    ch_mult = 8'b10_01_10_01;
    measure("R1 period 337", 337);
    count_pulses(337, 2, 4, 2, 4);
    wait_base();
    @(negedge clk);
    chk("R9 base one cycle", int'(base_pulse), 0);

    repeat (3) @(negedge clk);
    print_summary();
    $finish;
  end
endmodule